// File: doc/BRIEF.md
# USB OUT Packet Acceptance Controller

This block decides how a USB device endpoint answers a data packet that arrives after an OUT token. It watches a single end-of-packet strobe together with already-decoded packet facts (data toggle, error flag, received byte count, token PID) and the control bits of the endpoint's buffer descriptor (engine ownership, toggle-check enable, expected toggle, buffer capacity). One cycle after the strobe it issues a handshake, tells the descriptor logic what the ownership bit becomes, and, only for an accepted packet, raises a transaction interrupt and writes the token PID and the 10-bit byte count back into the descriptor status.

The controller is a five-state machine. From `ST_IDLE` the transition taken on the strobe is chosen by a priority classifier: `ST_NAK_CPU` when software owns the descriptor, `ST_NAK_HELD` when the packet carries an error or exceeds the capacity, `ST_DUP` when toggle checking is on and the toggle does not match, otherwise `ST_ACCEPT`. Every response state lasts one cycle and returns unconditionally to `ST_IDLE`. Bit decoding, CRC and the payload path sit elsewhere.

Top module: `usb_out_acc_ctrl`

## Requirements
- R1: After reset, with no strobe, `hs_valid`, `trn_irq` and `stat_we` are 0.
- R2: A strobe sampled on `eop_stb` in the idle state makes `hs_valid` 1 in the following cycle only, and 0 in the cycle after that.
- R3: With `bd_own`=1, no error, count within capacity, `bd_chk_en`=1 and `rx_data1` equal to `bd_exp_data1` (1 = DATA1, 0 = DATA0), the answer is ACK (`hs_ack`=1), `own_next`=0, `trn_irq`=1 and `stat_we`=1.
- R4: With toggle checking on and `rx_data1` differing from `bd_exp_data1` (no error, within capacity, owned), the answer is ACK with `own_next`=1, `trn_irq`=0 and `stat_we`=0.
- R5: With `bd_chk_en`=0, an owned, error-free, in-capacity packet of either toggle is accepted exactly as in R3.
- R6: A packet with `rx_err`=1 on an owned descriptor is answered NAK (`hs_ack`=0) with `own_next`=1, no interrupt and no status write.
- R7: A count strictly greater than `bd_max_cnt` is answered NAK with `own_next`=1, no interrupt and no status write; a count equal to the capacity is accepted.
- R8: On a status write, `stat_pid` carries the token PID and the received count is split: bits 7..0 on `stat_cnt_lo`, bits 9..8 on `stat_cnt_hi`, covering 0 to 1023.
- R9: With `bd_own`=0 the answer is NAK, `own_next`=0, no interrupt and no status write.
- R10: Outcome priority is ownership, then error, then oversize, then toggle: an errored or oversize packet with a toggle mismatch is NAKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eop_stb | input | 1 | One-cycle end-of-packet strobe for a received data packet |
| rx_data1 | input | 1 | Received data PID toggle, 1 = DATA1, 0 = DATA0 |
| rx_err | input | 1 | Packet arrived with an error |
| rx_cnt | input | 10 | Received byte count |
| tok_pid | input | 4 | PID of the token that opened the transaction |
| bd_own | input | 1 | Descriptor owned by the engine |
| bd_chk_en | input | 1 | Toggle checking enabled |
| bd_exp_data1 | input | 1 | Expected toggle, 1 = DATA1 |
| bd_max_cnt | input | 10 | Buffer capacity in bytes |
| hs_valid | output | 1 | Handshake decision valid this cycle |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK, meaningful with hs_valid |
| own_next | output | 1 | Ownership bit the descriptor takes, meaningful with hs_valid |
| trn_irq | output | 1 | Transaction-complete interrupt pulse |
| stat_we | output | 1 | Write enable for descriptor status and count |
| stat_pid | output | 4 | Token PID to store in the status PID field |
| stat_cnt_lo | output | 8 | Low 8 bits of the received count |
| stat_cnt_hi | output | 2 | Upper 2 bits of the received count |

## Verification
The assertions take for granted that `eop_stb` is a single-cycle pulse that never arrives while a response is being issued, and that the packet and descriptor inputs are steady in the strobe cycle; their `$past` checks on counts and ownership rely on that. The bench drives each packet as one strobe cycle followed by at least two idle cycles, so every strobe lands in `ST_IDLE`, and it sets all inputs at the falling edge before the strobe is sampled.

// File: rtl/usb_out_acc_pkg.sv
package usb_out_acc_pkg;

    // Response state of the acceptance controller
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ACCEPT   = 3'd1,
        ST_DUP      = 3'd2,
        ST_NAK_HELD = 3'd3,
        ST_NAK_CPU  = 3'd4
    } rsp_state_e;

    // Classifier verdict for a received packet
    typedef enum logic [1:0] {
        VRD_ACCEPT   = 2'd0,
        VRD_DUP      = 2'd1,
        VRD_NAK_HELD = 2'd2,
        VRD_NAK_CPU  = 2'd3
    } verdict_e;

endpackage

// File: rtl/usb_out_classify.sv
module usb_out_classify
    import usb_out_acc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             own,
    input  logic             err,
    input  logic             chk_en,
    input  logic             rx_data1,
    input  logic             exp_data1,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] max_cnt,
    output verdict_e         verdict
);

    logic oversize;
    logic toggle_bad;

    assign oversize   = (rx_cnt > max_cnt);
    assign toggle_bad = chk_en && (rx_data1 != exp_data1);

    // Priority: ownership, error, oversize, toggle (R10)
    always_comb begin
        if (!own) begin
            verdict = VRD_NAK_CPU;
        end else if (err || oversize) begin
            verdict = VRD_NAK_HELD;
        end else if (toggle_bad) begin
            verdict = VRD_DUP;
        end else begin
            verdict = VRD_ACCEPT;
        end
    end

endmodule

// File: rtl/usb_out_capture.sv
module usb_out_capture #(
    parameter int CNT_W = 10,
    parameter int PID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PID_W-1:0] pid_in,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [PID_W-1:0] pid_q,
    output logic [CNT_W-1:0] cnt_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            pid_q <= pid_in;
            cnt_q <= cnt_in;
        end
    end

endmodule

// File: rtl/usb_out_stat_fmt.sv
module usb_out_stat_fmt #(
    parameter int CNT_W = 10,
    parameter int LO_W  = 8,
    parameter int PID_W = 4
) (
    input  logic                   we,
    input  logic [PID_W-1:0]       pid_in,
    input  logic [CNT_W-1:0]       cnt_in,
    output logic [PID_W-1:0]       pid_out,
    output logic [LO_W-1:0]        lo_out,
    output logic [CNT_W-LO_W-1:0]  hi_out
);

    localparam int HI_W = CNT_W - LO_W;

    // Fields are driven only during a write, zero otherwise (R8)
    always_comb begin
        if (we) begin
            pid_out = pid_in;
            lo_out  = cnt_in[LO_W-1:0];
            hi_out  = cnt_in[CNT_W-1:LO_W];
        end else begin
            pid_out = '0;
            lo_out  = '0;
            hi_out  = {HI_W{1'b0}};
        end
    end

endmodule

// File: rtl/usb_out_acc_ctrl.sv
module usb_out_acc_ctrl
    import usb_out_acc_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LO_W  = 8,
    parameter int PID_W = 4,
    localparam int HI_W = CNT_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eop_stb,
    input  logic             rx_data1,
    input  logic             rx_err,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [PID_W-1:0] tok_pid,
    input  logic             bd_own,
    input  logic             bd_chk_en,
    input  logic             bd_exp_data1,
    input  logic [CNT_W-1:0] bd_max_cnt,
    output logic             hs_valid,
    output logic             hs_ack,
    output logic             own_next,
    output logic             trn_irq,
    output logic             stat_we,
    output logic [PID_W-1:0] stat_pid,
    output logic [LO_W-1:0]  stat_cnt_lo,
    output logic [HI_W-1:0]  stat_cnt_hi
);

    rsp_state_e       state_q, state_d;
    verdict_e         verdict;
    logic             take;
    logic [PID_W-1:0] pid_held;
    logic [CNT_W-1:0] cnt_held;

    assign take = eop_stb && (state_q == ST_IDLE);

    usb_out_classify #(.CNT_W(CNT_W)) classify_i (
        .own       (bd_own),
        .err       (rx_err),
        .chk_en    (bd_chk_en),
        .rx_data1  (rx_data1),
        .exp_data1 (bd_exp_data1),
        .rx_cnt    (rx_cnt),
        .max_cnt   (bd_max_cnt),
        .verdict   (verdict)
    );

    usb_out_capture #(.CNT_W(CNT_W), .PID_W(PID_W)) capture_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take),
        .pid_in (tok_pid),
        .cnt_in (rx_cnt),
        .pid_q  (pid_held),
        .cnt_q  (cnt_held)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (eop_stb) begin
                    unique case (verdict)
                        VRD_ACCEPT:   state_d = ST_ACCEPT;
                        VRD_DUP:      state_d = ST_DUP;
                        VRD_NAK_HELD: state_d = ST_NAK_HELD;
                        VRD_NAK_CPU:  state_d = ST_NAK_CPU;
                    endcase
                end
            end
            ST_ACCEPT, ST_DUP, ST_NAK_HELD, ST_NAK_CPU: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs by state
    always_comb begin
        hs_valid = 1'b0;
        hs_ack   = 1'b0;
        own_next = 1'b0;
        trn_irq  = 1'b0;
        stat_we  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACCEPT: begin
                hs_valid = 1'b1;
                hs_ack   = 1'b1;
                trn_irq  = 1'b1;
                stat_we  = 1'b1;
            end
            ST_DUP: begin
                hs_valid = 1'b1;
                hs_ack   = 1'b1;
                own_next = 1'b1;
            end
            ST_NAK_HELD: begin
                hs_valid = 1'b1;
                own_next = 1'b1;
            end
            ST_NAK_CPU: begin
                hs_valid = 1'b1;
            end
            default: ;
        endcase
    end

    usb_out_stat_fmt #(.CNT_W(CNT_W), .LO_W(LO_W), .PID_W(PID_W)) fmt_i (
        .we      (stat_we),
        .pid_in  (pid_held),
        .cnt_in  (cnt_held),
        .pid_out (stat_pid),
        .lo_out  (stat_cnt_lo),
        .hi_out  (stat_cnt_hi)
    );

    // Assertions
    assert_hs_after_eop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_stb && state_q == ST_IDLE) |=> hs_valid);

    assert_hs_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    assert_irq_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trn_irq |-> (hs_valid && hs_ack && !own_next && stat_we));

    assert_we_only_on_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |-> trn_irq);

    assert_nak_keeps_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && !hs_ack) |-> (own_next == $past(bd_own)));

    assert_cnt_within_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |-> ({stat_cnt_hi, stat_cnt_lo} <= $past(bd_max_cnt)));

    assert_cpu_owned_nak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && !$past(bd_own)) |-> (!hs_ack && !trn_irq));

endmodule

// File: tb/usb_out_acc_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_out_acc_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eop_stb = 1'b0, rx_data1 = 1'b0, rx_err = 1'b0;
    logic [9:0] rx_cnt = '0, bd_max_cnt = '0;
    logic [3:0] tok_pid = '0;
    logic       bd_own = 1'b0, bd_chk_en = 1'b0, bd_exp_data1 = 1'b0;
    logic       hs_valid, hs_ack, own_next, trn_irq, stat_we;
    logic [3:0] stat_pid;
    logic [7:0] stat_cnt_lo;
    logic [1:0] stat_cnt_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       ack;
        logic       own;
        logic       irq;
        logic       we;
        logic [3:0] pid;
        logic [9:0] cnt;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    usb_out_acc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .eop_stb(eop_stb), .rx_data1(rx_data1),
        .rx_err(rx_err), .rx_cnt(rx_cnt), .tok_pid(tok_pid), .bd_own(bd_own),
        .bd_chk_en(bd_chk_en), .bd_exp_data1(bd_exp_data1), .bd_max_cnt(bd_max_cnt),
        .hs_valid(hs_valid), .hs_ack(hs_ack), .own_next(own_next), .trn_irq(trn_irq),
        .stat_we(stat_we), .stat_pid(stat_pid), .stat_cnt_lo(stat_cnt_lo),
        .stat_cnt_hi(stat_cnt_hi)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: computes the expected result from the requirements and pushes it
    task automatic send(input logic d1, input logic err, input logic [9:0] cnt,
                        input logic [9:0] cap, input logic [3:0] pid, input logic own,
                        input logic chk, input logic expd, input string tag);
        exp_t e;
        e.pid = pid; e.cnt = cnt; e.tag = tag;
        if (!own) begin
            e.ack = 0; e.own = 0; e.irq = 0; e.we = 0;           // R9
        end else if (err || cnt > cap) begin
            e.ack = 0; e.own = 1; e.irq = 0; e.we = 0;           // R6 R7 R10
        end else if (chk && d1 != expd) begin
            e.ack = 1; e.own = 1; e.irq = 0; e.we = 0;           // R4
        end else begin
            e.ack = 1; e.own = 0; e.irq = 1; e.we = 1;           // R3 R5
        end
        exp_q.push_back(e);
        @(negedge clk);
        rx_data1 = d1; rx_err = err; rx_cnt = cnt; bd_max_cnt = cap; tok_pid = pid;
        bd_own = own; bd_chk_en = chk; bd_exp_data1 = expd; eop_stb = 1'b1;
        @(negedge clk);
        eop_stb = 1'b0;
        check(hs_valid === 1'b1, "R2", "hs_valid after strobe", hs_valid, 1);
        @(negedge clk);
        check(hs_valid === 1'b0, "R2", "hs_valid second cycle", hs_valid, 0);
        @(negedge clk);
    endtask

    // Monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (rst_n && hs_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected handshake", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(hs_ack === e.ack, e.tag, "hs_ack", hs_ack, e.ack);
                check(own_next === e.own, e.tag, "own_next", own_next, e.own);
                check(trn_irq === e.irq, e.tag, "trn_irq", trn_irq, e.irq);
                check(stat_we === e.we, e.tag, "stat_we", stat_we, e.we);
                if (e.we) begin
                    check(stat_pid === e.pid, "R8", "stat_pid", stat_pid, e.pid);
                    check(stat_cnt_lo === e.cnt[7:0], "R8", "stat_cnt_lo", stat_cnt_lo, e.cnt[7:0]);
                    check(stat_cnt_hi === e.cnt[9:8], "R8", "stat_cnt_hi", stat_cnt_hi, e.cnt[9:8]);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            check(1'b0, "WATCHDOG", "timeout", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(hs_valid === 1'b0, "R1", "hs_valid after reset", hs_valid, 0);
        check(trn_irq === 1'b0, "R1", "trn_irq after reset", trn_irq, 0);
        check(stat_we === 1'b0, "R1", "stat_we after reset", stat_we, 0);

        //    d1 err cnt    cap    pid    own chk exp
        send(0, 0, 10'd8,   10'd64,  4'h1, 1, 1, 0, "R3");
        send(1, 0, 10'd64,  10'd64,  4'h1, 1, 1, 1, "R3");
        send(0, 0, 10'd8,   10'd64,  4'h1, 1, 1, 1, "R4");
        send(1, 0, 10'd8,   10'd64,  4'h1, 1, 1, 0, "R4");
        send(0, 0, 10'd3,   10'd64,  4'h9, 1, 0, 1, "R5");
        send(1, 0, 10'd5,   10'd64,  4'h9, 1, 0, 0, "R5");
        send(0, 1, 10'd8,   10'd64,  4'h1, 1, 1, 0, "R6");
        send(1, 1, 10'd8,   10'd64,  4'h1, 1, 0, 0, "R6");
        send(0, 0, 10'd65,  10'd64,  4'h1, 1, 1, 0, "R7");
        send(0, 0, 10'd64,  10'd64,  4'h1, 1, 1, 0, "R7");
        send(1, 0, 10'd1023,10'd1023,4'hE, 1, 0, 0, "R8");
        send(0, 0, 10'd0,   10'd0,   4'h5, 1, 1, 0, "R8");
        send(1, 0, 10'd300, 10'd512, 4'h1, 1, 1, 1, "R8");
        send(0, 0, 10'd8,   10'd64,  4'h1, 0, 1, 0, "R9");
        send(1, 1, 10'd8,   10'd64,  4'h1, 0, 0, 0, "R9");
        send(1, 1, 10'd8,   10'd64,  4'h1, 1, 1, 0, "R10");
        send(1, 0, 10'd100, 10'd64,  4'h1, 1, 1, 0, "R10");
        send(0, 0, 10'd100, 10'd64,  4'h1, 0, 1, 1, "R10");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending results", exp_q.size(), 0);
        check(trn_irq === 1'b0 && stat_we === 1'b0, "R1", "quiet when idle", trn_irq, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule